// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked request port and a byte-wide asynchronous static RAM with a 19-bit address. A client offers one access at a time on a valid/ready handshake. It gives a write flag, an address and, for writes, one data byte. The controller then runs the chip-select, write-enable and output-enable strobes of the memory. All three strobes are active low. Read data comes back on its own port with a single-cycle valid strobe. The memory data bus is split into an output byte, an input byte and one drive-enable, so a pad ring or test model can join them.

The memory timing limits are written in nanoseconds for two speed grades, a fast one and a slow one. A parameter selects the grade. At elaboration, each limit becomes a whole number of clock cycles for the clock period given as a parameter: the ceiling of limit/period, never less than one cycle. Every access length is built from these counts.

Handshake rules: a request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. While `req_ready` is low, the client may hold or change its request, and none of it is sampled. The response port has no back-pressure. `rsp_valid` is a one-cycle pulse, and the client must take `rsp_data` in that cycle or keep its own copy.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are high, `sram_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write drives the address and the data for one cycle with chip select low and write enable high. It then holds write enable low for the strobe count. Write enable and chip select rise at the same edge. The data is driven from the first cycle of the write until one cycle after the strobe ends, and that data is what the memory stores.
- R3: Strobe count = max(ceil(tWP), ceil(tCW)-1, ceil(tAW)-1, ceil(tDW)-1). A write keeps `req_ready` low for 1 + strobe + max(1, ceil(tWC)-1-strobe) cycles. Fast grade at 10 ns: 4 strobe cycles, 5 chip-select cycles, 6 busy cycles.
- R4: A read holds chip select and output enable low for max(ceil(tRC), ceil(tAA), ceil(tCO), ceil(tOE)) cycles (6 at 10 ns, fast grade). It captures the memory data at the edge that ends the last of these cycles, and raises `rsp_valid` for exactly one cycle with that byte.
- R5: After every read, all strobes stay high and the data drivers stay off for ceil(tRelease) cycles (2 at 10 ns, fast grade) before another request can be taken. A read therefore keeps `req_ready` low for access + release cycles (8). This gives at least one idle cycle between a read and a following write.
- R6: `sram_dq_oe` is never high while `sram_oe_n` is low, and `sram_oe_n` and `sram_we_n` are never low together.
- R7: `sram_addr` does not change while `sram_cs_n` stays low.
- R8: `req_ready` is low in every cycle where chip select is low. A request offered while `req_ready` is low is not taken and has no effect on the memory.
- R9: Addresses 0 and 2^19-1 and the data values 8'h00 and 8'hFF are written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; takes a request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 8 | Read data |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 19 | Memory address bus |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |

## Verification
The bench tests the read path against a memory model that returns inverted data until the expected access count has passed, so a read that finishes early returns a wrong byte. Single writes with read-back at the end addresses, and all-zero and all-ones bytes, separate a correct store from an address or data path that is stuck or cut short. Measured strobe widths and busy lengths tell a wrong cycle count apart from a wrong data path. A read followed directly by a write exposes a missing bus turnaround. A request held during a busy write shows whether the handshake ignores input while not ready.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WSTB  = 3'd2,
    ST_WTAIL = 3'd3,
    ST_RACC  = 3'd4,
    ST_RTURN = 3'd5
  } ctrl_state_t;

  // ceiling of ns / period, at least one cycle
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // timing limits in ns; slow = 0 selects the fast grade
  function automatic int lim_wcyc(input bit slow);  return slow ? 70 : 55; endfunction
  function automatic int lim_wpulse(input bit slow); return slow ? 50 : 40; endfunction
  function automatic int lim_cs_end(input bit slow); return slow ? 60 : 45; endfunction
  function automatic int lim_ad_end(input bit slow); return slow ? 60 : 45; endfunction
  function automatic int lim_dsetup(input bit slow); return slow ? 30 : 25; endfunction
  function automatic int lim_rcyc(input bit slow);  return slow ? 70 : 55; endfunction
  function automatic int lim_aacc(input bit slow);  return slow ? 70 : 55; endfunction
  function automatic int lim_csacc(input bit slow); return slow ? 70 : 55; endfunction
  function automatic int lim_oeacc(input bit slow); return slow ? 35 : 25; endfunction
  function automatic int lim_release(input bit slow); return slow ? 25 : 20; endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int STB_CYC  = 4,
  parameter int TAIL_CYC = 1,
  parameter int ACC_CYC  = 6,
  parameter int TURN_CYC = 2,
  parameter int CNT_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  output ctrl_state_t state,
  output logic        capture
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ctrl_state_t      state_d;

  localparam logic [CNT_W-1:0] STB_LD  = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  wire last = (cnt_q == '0);

  always_comb begin
    state_d = state;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_d = start_wr ? ST_WSET : ST_RACC;
          cnt_d   = start_wr ? '0 : ACC_LD;
        end
      end
      ST_WSET:  if (last) begin state_d = ST_WSTB;  cnt_d = STB_LD;  end
      ST_WSTB:  if (last) begin state_d = ST_WTAIL; cnt_d = TAIL_LD; end
      ST_WTAIL: if (last) begin state_d = ST_IDLE;  cnt_d = '0;      end
      ST_RACC:  if (last) begin state_d = ST_RTURN; cnt_d = TURN_LD; end
      ST_RTURN: if (last) begin state_d = ST_IDLE;  cnt_d = '0;      end
      default: begin state_d = ST_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      cnt_q <= cnt_d;
    end
  end

  assign capture = (state == ST_RACC) && last;

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_t state,
  output logic        cs_n,
  output logic        we_n,
  output logic        oe_n,
  output logic        dq_oe,
  output logic        idle
);

  always_comb begin
    cs_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    idle  = 1'b0;
    unique case (state)
      ST_IDLE:  idle = 1'b1;
      ST_WSET:  begin cs_n = 1'b0; dq_oe = 1'b1; end
      ST_WSTB:  begin cs_n = 1'b0; we_n = 1'b0; dq_oe = 1'b1; end
      ST_WTAIL: dq_oe = 1'b1;
      ST_RACC:  begin cs_n = 1'b0; oe_n = 1'b0; end
      ST_RTURN: ;
      default:  ;
    endcase
  end

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= in_addr;
        wdata_q <= in_wdata;
      end
      if (capture) rdata_q <= mem_rdata;
      rvalid_q <= capture;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter bit SLOW_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  // cycle counts derived from the selected grade
  localparam int WC_C  = ns2cyc(lim_wcyc(SLOW_GRADE),   CLK_NS);
  localparam int WP_C  = ns2cyc(lim_wpulse(SLOW_GRADE), CLK_NS);
  localparam int CW_C  = ns2cyc(lim_cs_end(SLOW_GRADE), CLK_NS);
  localparam int AW_C  = ns2cyc(lim_ad_end(SLOW_GRADE), CLK_NS);
  localparam int DW_C  = ns2cyc(lim_dsetup(SLOW_GRADE), CLK_NS);
  localparam int RC_C  = ns2cyc(lim_rcyc(SLOW_GRADE),   CLK_NS);
  localparam int AA_C  = ns2cyc(lim_aacc(SLOW_GRADE),   CLK_NS);
  localparam int CO_C  = ns2cyc(lim_csacc(SLOW_GRADE),  CLK_NS);
  localparam int OE_C  = ns2cyc(lim_oeacc(SLOW_GRADE),  CLK_NS);
  localparam int REL_C = ns2cyc(lim_release(SLOW_GRADE), CLK_NS);

  // one set-up cycle precedes the strobe, so chip select, address and data
  // already count one cycle toward their end-of-write minimums
  localparam int STB_CYC  = imax(imax(WP_C, CW_C - 1), imax(AW_C - 1, DW_C - 1));
  localparam int TAIL_CYC = imax(1, WC_C - 1 - STB_CYC);
  localparam int ACC_CYC  = imax(imax(RC_C, AA_C), imax(CO_C, OE_C));
  localparam int TURN_CYC = REL_C;
  localparam int MAX_CYC  = imax(imax(STB_CYC, TAIL_CYC), imax(ACC_CYC, TURN_CYC));
  localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

  ctrl_state_t state;
  logic        capture;
  logic        idle;
  logic        accept;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  sram_seq_fsm #(
    .STB_CYC (STB_CYC),
    .TAIL_CYC(TAIL_CYC),
    .ACC_CYC (ACC_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .start_wr(req_write),
    .state   (state),
    .capture (capture)
  );

  sram_pin_decode u_dec (
    .state(state),
    .cs_n (sram_cs_n),
    .we_n (sram_we_n),
    .oe_n (sram_oe_n),
    .dq_oe(sram_dq_oe),
    .idle (idle)
  );

  sram_req_latch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .capture  (capture),
    .mem_rdata(sram_dq_in),
    .addr_q   (sram_addr),
    .wdata_q  (sram_dq_out),
    .rdata_q  (rsp_data),
    .rvalid_q (rsp_valid)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 19,
  parameter int TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe
);

  logic [7:0] oe_hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_hi_run <= 8'(TURN_CYC);
    else if (!sram_oe_n) oe_hi_run <= '0;
    else if (oe_hi_run != 8'hFF) oe_hi_run <= oe_hi_run + 8'd1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready);
    end
  end

  // R2
  write_end_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $rose(sram_cs_n));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_run >= 8'(TURN_CYC)));

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R6
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr));

  // R8
  busy_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready);

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sram_cs_n (sram_cs_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_addr (sram_addr),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int PER = 10;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected counts, fast grade
  localparam int E_STB  = mx(mx(cdiv(40), cdiv(45) - 1), mx(cdiv(45) - 1, cdiv(25) - 1));
  localparam int E_WBSY = 1 + E_STB + mx(1, cdiv(55) - 1 - E_STB);
  localparam int E_ACC  = mx(mx(cdiv(55), cdiv(55)), mx(cdiv(55), cdiv(25)));
  localparam int E_TURN = cdiv(20);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rsp_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  always #(PER/2) clk = ~clk;

  sram_async_ctrl dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // small tagged memory model
  logic [AW-1:0] tag_a [16];
  logic [DW-1:0] tag_d [16];
  logic          tag_v [16];
  int            n_tag = 0;

  function automatic logic [DW-1:0] mlook(input logic [AW-1:0] a);
    for (int i = 0; i < 16; i++) if (tag_v[i] && tag_a[i] == a) return tag_d[i];
    return 8'h00;
  endfunction

  task automatic mstore(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int i = 0; i < 16; i++)
      if (tag_v[i] && tag_a[i] == a) begin tag_d[i] = d; return; end
    tag_a[n_tag % 16] = a; tag_d[n_tag % 16] = d; tag_v[n_tag % 16] = 1'b1;
    n_tag++;
  endtask

  // monitor state
  logic [DW-1:0] rd_model = '0;
  int  acc = 0;
  bit  wact_p = 0;
  logic [AW-1:0] wa_q = '0;
  logic [DW-1:0] wd_q = '0;
  int  we_run = 0, cs_run = 0, oe_run = 0;
  int  last_we = 0, last_cs = 0, last_oe = 0;
  int  oe_hi = 100, drv_gap = 0;
  bit  dqoe_p = 0;
  int  rv_cnt = 0;
  logic [DW-1:0] rv_data = '0;
  int  fight = 0, addr_mv = 0;
  logic [AW-1:0] addr_p = '0;
  bit  cs_p = 1;

  assign sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n) ?
                      ((acc >= E_ACC - 1) ? rd_model : ~rd_model) : 8'h00;

  always @(posedge clk) acc <= (!sram_cs_n && !sram_oe_n) ? acc + 1 : 0;

  initial for (int i = 0; i < 16; i++) tag_v[i] = 1'b0;

  always @(negedge clk) if (rst_n) begin
    rd_model = mlook(sram_addr);
    if (wact_p && !(!sram_cs_n && !sram_we_n)) mstore(wa_q, wd_q);
    wact_p = !sram_cs_n && !sram_we_n;
    if (wact_p) begin wa_q = sram_addr; wd_q = sram_dq_oe ? sram_dq_out : 8'h00; end
    if (!sram_we_n) we_run++; else if (we_run != 0) begin last_we = we_run; we_run = 0; end
    if (!sram_cs_n) cs_run++; else if (cs_run != 0) begin last_cs = cs_run; cs_run = 0; end
    if (!sram_oe_n) oe_run++; else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
    if (sram_dq_oe && !dqoe_p) drv_gap = oe_hi;
    dqoe_p = sram_dq_oe;
    if (!sram_oe_n) oe_hi = 0; else oe_hi++;
    if (rsp_valid) begin rv_cnt++; rv_data = rsp_data; end
    if (sram_dq_oe && !sram_oe_n) fight++;
    if (!sram_oe_n && !sram_we_n) fight++;
    if (!sram_cs_n && !cs_p && sram_addr != addr_p) addr_mv++;
    if (!sram_cs_n && !req_ready) ; else if (!sram_cs_n) fight++;
    cs_p = sram_cs_n; addr_p = sram_addr;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, output int busy);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    busy = 0;
    forever begin
      @(negedge clk);
      if (req_ready || busy > 1000) break;
      busy++;
    end
  endtask

  task automatic t_reset();
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1", "strobes high", {sram_cs_n, sram_we_n, sram_oe_n}, 7);
    chk(!sram_dq_oe, "R1", "drivers off", sram_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1", "ready/rsp", {req_ready, rsp_valid}, 2);
  endtask

  task automatic t_write_timing();
    int b;
    do_req(1'b1, 19'h00123, 8'hA5, b);
    chk(last_we == E_STB, "R3", "strobe cycles", last_we, E_STB);
    chk(last_cs == E_STB + 1, "R2", "chip select cycles", last_cs, E_STB + 1);
    chk(b == E_WBSY, "R3", "write busy", b, E_WBSY);
  endtask

  task automatic t_read_back(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    int b, rv0;
    rv0 = rv_cnt;
    do_req(1'b0, a, 8'h00, b);
    chk(rv_data == exp, req, "read data", rv_data, exp);
    chk(rv_cnt == rv0 + 1, "R4", "one rsp pulse", rv_cnt - rv0, 1);
    chk(last_oe == E_ACC, "R4", "access cycles", last_oe, E_ACC);
    chk(b == E_ACC + E_TURN, "R5", "read busy", b, E_ACC + E_TURN);
  endtask

  task automatic t_boundary();
    int b;
    do_req(1'b1, 19'h7FFFF, 8'hFF, b);
    do_req(1'b1, 19'h00000, 8'h00, b);
    t_read_back(19'h7FFFF, 8'hFF, "R9");
    t_read_back(19'h00000, 8'h00, "R9");
  endtask

  task automatic t_read_then_write();
    int b;
    do_req(1'b0, 19'h00123, 8'h00, b);
    do_req(1'b1, 19'h2AAAA, 8'h5C, b);
    chk(drv_gap >= E_TURN, "R5", "gap before drive", drv_gap, E_TURN);
    t_read_back(19'h2AAAA, 8'h5C, "R2");
  endtask

  task automatic t_ignore_busy();
    int b;
    do_req(1'b1, 19'h15555, 8'h3C, b);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h0FFFF; req_wdata = 8'h11;
    @(posedge clk); #1;
    req_write = 1'b1; req_addr = 19'h15555; req_wdata = 8'hEE;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R8", "ready low while busy", req_ready, 0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    t_read_back(19'h15555, 8'h3C, "R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_timing();
    t_read_back(19'h00123, 8'hA5, "R4");
    t_boundary();
    t_read_then_write();
    t_ignore_busy();
    chk(fight == 0, "R6", "bus or strobe conflicts", fight, 0);
    chk(addr_mv == 0, "R7", "address moves under select", addr_mv, 0);
    finish_run();
  end

endmodule